// File: doc/BRIEF.md
# Saturating Counting Semaphore Cell

This block holds one 16-bit counting semaphore that several hardware threads share through a memory-mapped cell. A load from the cell is a take (P) operation. It returns the count as it stood before the access and then lowers the count by one, but never below zero. A store to the cell is a give (V) operation. It raises the count by one, and the count stops at 0xFFFF. A store carries no operand, because only the increment matters.

Each access names the issuing thread and one of two views. In the waiting view, a take that finds the count at zero stalls the thread. The cell reports the stall and marks the thread in a per-thread bitmap. In the non-waiting view, the same take returns zero and leaves no mark. A give that lifts the count off zero releases every marked thread with a one-cycle pulse and clears the whole bitmap. The released threads then retry and compete for the count. The cell tag reports a non-queue cell type.

Top module: `pv_sem_cell`

## Requirements
- R1: Asynchronous reset (rst_n low) sets the count to 0, the bitmap to all zeros, and rsp_valid, rsp_blocked and wake_pulse to 0.
- R2: Every accepted request (req_valid high at a rising edge) produces exactly one response, with rsp_valid high in the following cycle only.
- R3: A take (req_write=0) at a nonzero count returns the pre-access count on rsp_data, with rsp_blocked=0, and the count drops by exactly one.
- R4: A give (req_write=1) returns the pre-access count on rsp_data and raises the count by one, holding at 0xFFFF once that value is reached.
- R5: A take in the waiting view (req_try=0) at count 0 returns rsp_data=0 with rsp_blocked=1, leaves the count at 0 and sets bit req_tid of blocked_map. Bits that are already set stay set.
- R6: A take in the non-waiting view (req_try=1) at count 0 returns rsp_data=0 with rsp_blocked=0 and changes neither the count nor blocked_map.
- R7: A give at count 0 drives wake_pulse equal to the bitmap as it was before the give, for exactly one cycle, in the same cycle as its response, and clears blocked_map in that cycle.
- R8: A give at a nonzero count leaves wake_pulse at zero and blocked_map unchanged. wake_pulse is zero in every cycle that carries no give response.
- R9: At a nonzero count the two views behave identically.
- R10: tag_fifo_type is always 0, which marks a semaphore cell. No access changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_tid | input | TID_W (2) | Issuing thread number |
| req_write | input | 1 | 1 = give (store), 0 = take (load) |
| req_try | input | 1 | 1 = non-waiting view, 0 = waiting view |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_data | output | CNT_W (16) | Count before the access |
| rsp_blocked | output | 1 | Issuing thread is now stalled |
| blocked_map | output | NTHR (4) | One bit per stalled thread |
| wake_pulse | output | NTHR (4) | One-cycle release of stalled threads |
| tag_fifo_type | output | 1 | Cell-type tag bit, 0 for semaphore |

## Verification
Two functions can coincide in one cycle. The release pulse that a give from zero produces can appear in the same cycle as the released thread's next take arriving. The bench provokes this by issuing a give at count 0 while threads are stalled, then a take from a released thread on the very next cycle. Its scoreboard checks that the pulse carries the old bitmap, that the bitmap is already empty, and that the retried take wins the single unit without stalling again. Back-to-back gives and takes at the saturation limit and at zero are judged the same way against the bench's own model of count and bitmap.

// File: rtl/pv_sem_pkg.sv
package pv_sem_pkg;
  typedef enum logic {
    VIEW_WAIT = 1'b0,
    VIEW_TRY  = 1'b1
  } pv_view_e;

  typedef struct packed {
    logic     take;
    logic     give;
    pv_view_e view;
  } pv_op_t;
endpackage

// File: rtl/pv_count_unit.sv
module pv_count_unit
  import pv_sem_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_q,
  input  pv_op_t           op,
  output logic [CNT_W-1:0] cnt_d,
  output logic [CNT_W-1:0] rsp_data_d,
  output logic             stall_d,
  output logic             rise_from_zero
);
  logic at_zero;
  logic at_max;

  assign at_zero = (cnt_q == '0);
  assign at_max  = &cnt_q;

  always_comb begin
    cnt_d          = cnt_q;
    rsp_data_d     = cnt_q;
    stall_d        = 1'b0;
    rise_from_zero = 1'b0;
    if (op.take) begin
      if (!at_zero) begin
        cnt_d = cnt_q - CNT_W'(1);
      end else if (op.view == VIEW_WAIT) begin
        stall_d = 1'b1;
      end
    end else if (op.give) begin
      if (!at_max) begin
        cnt_d = cnt_q + CNT_W'(1);
      end
      rise_from_zero = at_zero;
    end
  end
endmodule

// File: rtl/pv_wait_tracker.sv
module pv_wait_tracker #(
  parameter int NTHR  = 4,
  parameter int TID_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mark_en,
  input  logic [TID_W-1:0] mark_tid,
  input  logic             release_en,
  output logic [NTHR-1:0]  map_q,
  output logic [NTHR-1:0]  wake_q
);
  logic [NTHR-1:0] map_d;
  logic [NTHR-1:0] wake_d;
  logic            map_ce;

  assign map_ce = mark_en | release_en;

  for (genvar i = 0; i < NTHR; i++) begin : g_bit
    always_comb begin
      if (release_en) begin
        map_d[i] = 1'b0;
      end else begin
        map_d[i] = map_q[i] | (mark_en && (mark_tid == TID_W'(i)));
      end
      wake_d[i] = release_en & map_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= '0;
    end else if (map_ce) begin
      map_q <= map_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q <= '0;
    end else begin
      wake_q <= wake_d;
    end
  end
endmodule

// File: rtl/pv_sem_cell.sv
module pv_sem_cell
  import pv_sem_pkg::*;
#(
  parameter int NTHR  = 4,
  parameter int CNT_W = 16,
  localparam int TID_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [TID_W-1:0] req_tid,
  input  logic             req_write,
  input  logic             req_try,
  output logic             rsp_valid,
  output logic [CNT_W-1:0] rsp_data,
  output logic             rsp_blocked,
  output logic [NTHR-1:0]  blocked_map,
  output logic [NTHR-1:0]  wake_pulse,
  output logic             tag_fifo_type
);
  pv_op_t           op;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] rsp_data_d;
  logic             stall_d;
  logic             rise_from_zero;
  logic             rsp_valid_q;
  logic [CNT_W-1:0] rsp_data_q;
  logic             rsp_blocked_q;

  always_comb begin
    op.take = req_valid & ~req_write;
    op.give = req_valid &  req_write;
    op.view = req_try ? VIEW_TRY : VIEW_WAIT;
  end

  pv_count_unit #(.CNT_W(CNT_W)) u_count (
    .cnt_q          (cnt_q),
    .op             (op),
    .cnt_d          (cnt_d),
    .rsp_data_d     (rsp_data_d),
    .stall_d        (stall_d),
    .rise_from_zero (rise_from_zero)
  );

  pv_wait_tracker #(.NTHR(NTHR), .TID_W(TID_W)) u_wait (
    .clk        (clk),
    .rst_n      (rst_n),
    .mark_en    (stall_d),
    .mark_tid   (req_tid),
    .release_en (rise_from_zero),
    .map_q      (blocked_map),
    .wake_q     (wake_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (req_valid) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
    end else begin
      rsp_valid_q <= req_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_data_q    <= '0;
      rsp_blocked_q <= 1'b0;
    end else if (req_valid) begin
      rsp_data_q    <= rsp_data_d;
      rsp_blocked_q <= stall_d;
    end
  end

  assign rsp_valid     = rsp_valid_q;
  assign rsp_data      = rsp_data_q;
  assign rsp_blocked   = rsp_blocked_q & rsp_valid_q;
  assign tag_fifo_type = 1'b0;
endmodule

// File: rtl/pv_sem_cell_chk.sv
module pv_sem_cell_chk #(
  parameter int NTHR  = 4,
  parameter int CNT_W = 16,
  parameter int TID_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [TID_W-1:0] req_tid,
  input logic             req_write,
  input logic             req_try,
  input logic             rsp_valid,
  input logic [CNT_W-1:0] rsp_data,
  input logic             rsp_blocked,
  input logic [NTHR-1:0]  blocked_map,
  input logic [NTHR-1:0]  wake_pulse,
  input logic [CNT_W-1:0] cnt_q
);
  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r3_take_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && (&cnt_q)) |=> (&cnt_q));

  a_r5_stall_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_blocked |-> (rsp_valid && rsp_data == '0));

  a_r5_stall_marks_thread: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !req_try && cnt_q == '0) |=> blocked_map[$past(req_tid)]);

  a_r6_try_never_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_try) |=> !rsp_blocked);

  a_r7_wake_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_pulse != '0) |=> (wake_pulse == '0));

  a_r7_wake_clears_map: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_pulse != '0) |-> (blocked_map == '0));

  a_r8_stalls_only_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked_map != '0) |-> (cnt_q == '0));
endmodule

bind pv_sem_cell pv_sem_cell_chk #(.NTHR(NTHR), .CNT_W(CNT_W), .TID_W(TID_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_tid     (req_tid),
  .req_write   (req_write),
  .req_try     (req_try),
  .rsp_valid   (rsp_valid),
  .rsp_data    (rsp_data),
  .rsp_blocked (rsp_blocked),
  .blocked_map (blocked_map),
  .wake_pulse  (wake_pulse),
  .cnt_q       (cnt_q)
);

// File: tb/pv_sem_cell_test.sv
module pv_sem_cell_test;
  localparam int CLK_PERIOD = 10;
  localparam int NTHR  = 4;
  localparam int CNT_W = 16;
  localparam int TID_W = 2;
  localparam int WATCHDOG = 150000;

  logic             clk;
  logic             rst_n;
  logic             req_valid;
  logic [TID_W-1:0] req_tid;
  logic             req_write;
  logic             req_try;
  logic             rsp_valid;
  logic [CNT_W-1:0] rsp_data;
  logic             rsp_blocked;
  logic [NTHR-1:0]  blocked_map;
  logic [NTHR-1:0]  wake_pulse;
  logic             tag_fifo_type;

  typedef struct {
    logic [CNT_W-1:0] data;
    logic             blk;
    logic [NTHR-1:0]  wake;
    logic [NTHR-1:0]  map;
    string            tag;
  } exp_t;

  exp_t sb[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  int   cycles   = 0;
  bit   done     = 0;
  bit   mon_on   = 0;

  logic [CNT_W-1:0] m_cnt;
  logic [NTHR-1:0]  m_map;

  pv_sem_cell #(.NTHR(NTHR), .CNT_W(CNT_W)) uut (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_tid (req_tid),
    .req_write (req_write), .req_try (req_try), .rsp_valid (rsp_valid),
    .rsp_data (rsp_data), .rsp_blocked (rsp_blocked), .blocked_map (blocked_map),
    .wake_pulse (wake_pulse), .tag_fifo_type (tag_fifo_type)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  // Driver: drives one request for one cycle and pushes the model's prediction.
  task automatic access(input int tid, input bit wr, input bit tr, input string tag);
    exp_t e;
    e.tag  = tag;
    e.data = m_cnt;
    e.blk  = 1'b0;
    e.wake = '0;
    if (!wr) begin
      if (m_cnt != 0) m_cnt = m_cnt - 1;
      else if (!tr) begin
        e.blk = 1'b1;
        m_map[tid] = 1'b1;
      end
    end else begin
      if (m_cnt == 0) begin
        e.wake = m_map;
        m_map  = '0;
      end
      if (m_cnt != 16'hFFFF) m_cnt = m_cnt + 1;
    end
    e.map = m_map;
    sb.push_back(e);
    req_valid = 1'b1;
    req_tid   = TID_W'(tid);
    req_write = wr;
    req_try   = tr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: compares responses against the scoreboard away from the active edge.
  always @(negedge clk) begin
    if (mon_on && !done) begin
      if (rsp_valid) begin
        if (sb.size() == 0) begin
          check("R2", "unexpected response", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(e.tag, "rsp_data", 32'(rsp_data), 32'(e.data));
          check(e.tag, "rsp_blocked", 32'(rsp_blocked), 32'(e.blk));
          check(e.tag, "wake_pulse", 32'(wake_pulse), 32'(e.wake));
          check(e.tag, "blocked_map", 32'(blocked_map), 32'(e.map));
        end
      end else if (wake_pulse != '0) begin
        check("R8", "wake without give", 32'(wake_pulse), 32'd0);
      end
    end
  end

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_tid = '0; req_write = 1'b0; req_try = 1'b0;
    m_cnt = '0; m_map = '0;
    idle(3);
    // R1 reset state
    check("R1", "rsp_valid", 32'(rsp_valid), 0);
    check("R1", "rsp_blocked", 32'(rsp_blocked), 0);
    check("R1", "blocked_map", 32'(blocked_map), 0);
    check("R1", "wake_pulse", 32'(wake_pulse), 0);
    check("R10", "tag_fifo_type", 32'(tag_fifo_type), 0);
    rst_n = 1'b1;
    mon_on = 1;
    idle(2);
    // R6 non-waiting take at zero
    access(3, 0, 1, "R6");
    idle(1);
    // R5 waiting takes at zero, repeated stall keeps bit
    access(1, 0, 0, "R5");
    access(2, 0, 0, "R5");
    access(1, 0, 0, "R5");
    idle(1);
    // R7 give from zero wakes; released thread retries on the next cycle
    access(0, 1, 0, "R7");
    access(1, 0, 0, "R7_retry");
    access(2, 0, 0, "R5_again");
    idle(2);
    // R4 / R8 gives from zero then nonzero
    access(0, 1, 0, "R7_empty");
    access(3, 1, 1, "R8");
    access(2, 1, 0, "R8");
    // R9 both views at nonzero count, R3 take decrements
    access(0, 0, 1, "R9");
    access(1, 0, 0, "R9");
    access(2, 0, 0, "R3");
    access(2, 0, 1, "R6_zero");
    idle(2);
    // R4 saturation: fill beyond the top
    for (int i = 0; i < 65540; i++) access(i % NTHR, 1, i[0], "R4");
    idle(2);
    access(0, 0, 0, "R4_sat_read");
    access(1, 1, 0, "R4");
    access(1, 1, 1, "R4");
    access(2, 0, 1, "R4_sat_read");
    idle(3);
    check("R10", "tag_fifo_type", 32'(tag_fifo_type), 0);
    check("R2", "scoreboard drained", 32'(sb.size()), 0);
    finish_run();
  end
endmodule